// File: doc/BRIEF.md
# Per-Port Round-Robin Memory Arbiter with Write-Conflict Chaining

This block picks one client from a fixed group of clients each cycle. The group shares a single RAM port. Each RAM port gets its own copy of the block, and every client is tied to exactly one port when the design is elaborated. The decision is registered and comes out in two forms. A one-hot grant vector lets each client handle its own local bookkeeping. A binary grantee index drives the port's address and data mux tree. A grant-valid flag and a grant-is-write flag go with them.

The per-port copies work together through a conflict link. While one arbiter is choosing a write, it raises its outgoing conflict signal. The next arbiter in the chain sees that signal on its incoming conflict input and refuses every write request in the same decision cycle, while still serving reads. The two write grants therefore never land in the same cycle. A parameter chooses whether an incoming conflict is also forwarded downstream, so chains longer than two can share one conflict.

Selection is round-robin. The search starts at a pointer and moves upward, wrapping past the last client. After each grant the pointer moves to the position just after the client that won.

Top module: `port_arbiter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `grant` is all zeros, and `grant_valid` and `grant_we` are low. The round-robin pointer restarts at client 0.
- R2: Each decision takes effect one clock edge after its inputs are sampled. `grant` has at most one bit set. `grant_valid` is high exactly when one bit is set. The set bit belongs to a client that was eligible in the previous cycle. `grant_valid` is low when no client was eligible.
- R3: While `grant_valid` is high, `grant_idx` holds the binary position of the set bit in `grant`.
- R4: The winner is the first eligible client found by scanning upward from the pointer, wrapping from client N_CLIENTS-1 to client 0. After a grant the pointer becomes (winner + 1) mod N_CLIENTS. With no grant the pointer does not change.
- R5: A client is eligible when its `req` bit is 1. When `conflict_in` is high, every client whose `req_we` bit is 1 is made ineligible for that cycle, while clients with `req_we` at 0 (reads) remain eligible. `grant_we` is high exactly when the registered winner had `req_we` set.
- R6: `conflict_out` is combinational. It is high during any cycle in which the current decision selects a write. A write selected in one cycle shows up on the next cycle as `grant_we` with `grant_valid`.
- R7: With CHAIN_PASS = 1, `conflict_out` is also high whenever `conflict_in` is high. With CHAIN_PASS = 0, `conflict_out` reflects only this arbiter's own write selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_CLIENTS | Request bit per client (bit i = client i) |
| req_we | input | N_CLIENTS | Per-client write intent, meaningful when the matching `req` bit is set |
| conflict_in | input | 1 | Conflict from the upstream arbiter; blocks writes this cycle |
| conflict_out | output | 1 | Conflict to the downstream arbiter; high while a write is being selected (plus pass-through) |
| grant | output | N_CLIENTS | Registered one-hot grant |
| grant_idx | output | max(1,clog2(N_CLIENTS)) | Registered binary index of the granted client |
| grant_valid | output | 1 | Registered: a grant is present |
| grant_we | output | 1 | Registered: the granted access is a write |

## Verification
The bench builds two copies of the arbiter. The first has five clients with forwarding on. Five is not a power of two, so the pointer wrap from client 4 back to client 0 is tested outside the case that a plain binary overflow would handle. The second has three clients with forwarding off, and its conflict input is driven by the first copy's conflict output. This setup covers same-cycle write blocking across the chain, the case where the downstream copy's own conflict output must stay low even though its input is high, and a downstream read being granted while its write neighbour is held back. A fixed scenario list comes first, followed by a deterministic pseudo-random request stream run against both copies at once.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Adds an offset to a position and wraps once into the range [0, n).
  function automatic int wrap_add(input int base, input int ofs, input int n);
    int s;
    s = base + ofs;
    if (s >= n) s = s - n;
    return s;
  endfunction

  // Width of a binary index that covers n entries (never below 1).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/arb_eligibility.sv
// Decides which requests may compete this cycle: while the upstream conflict
// is raised, write requests are held back and reads go through.
module arb_eligibility #(
  parameter int N_CLIENTS = 4
) (
  input  logic [N_CLIENTS-1:0] req,
  input  logic [N_CLIENTS-1:0] req_we,
  input  logic                 conflict_in,
  output logic [N_CLIENTS-1:0] elig
);

  logic [N_CLIENTS-1:0] write_block;

  always_comb begin
    write_block = req_we & {N_CLIENTS{conflict_in}};
    elig        = req & ~write_block;
  end

endmodule

// File: rtl/arb_rr_pick.sv
// Round-robin selection: the first eligible client found scanning upward from
// ptr, wrapping at N_CLIENTS. Returns the winner in both one-hot and binary form.
module arb_rr_pick #(
  parameter int N_CLIENTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [N_CLIENTS-1:0] elig,
  input  logic [IDX_W-1:0]     ptr,
  output logic                 found,
  output logic [IDX_W-1:0]     sel_idx,
  output logic [N_CLIENTS-1:0] sel_onehot
);

  int pos;

  always_comb begin
    found      = 1'b0;
    sel_idx    = '0;
    sel_onehot = '0;
    pos        = 0;
    for (int i = 0; i < N_CLIENTS; i++) begin
      pos = arb_pkg::wrap_add(int'(ptr), i, N_CLIENTS);
      if (!found && elig[pos]) begin
        found           = 1'b1;
        sel_idx         = pos[IDX_W-1:0];
        sel_onehot[pos] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/arb_conflict_link.sv
// Drives the outgoing conflict: this arbiter's own write selection, plus the
// incoming conflict when forwarding is enabled.
module arb_conflict_link #(
  parameter bit CHAIN_PASS = 1'b1
) (
  input  logic own_write,
  input  logic conflict_in,
  output logic conflict_out
);

  localparam logic PASS_EN = CHAIN_PASS;

  assign conflict_out = own_write | (PASS_EN & conflict_in);

endmodule

// File: rtl/port_arbiter.sv
module port_arbiter #(
  parameter int N_CLIENTS  = 4,
  parameter bit CHAIN_PASS = 1'b1,
  localparam int IDX_W     = arb_pkg::idx_width(N_CLIENTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_CLIENTS-1:0] req,
  input  logic [N_CLIENTS-1:0] req_we,
  input  logic                 conflict_in,
  output logic                 conflict_out,
  output logic [N_CLIENTS-1:0] grant,
  output logic [IDX_W-1:0]     grant_idx,
  output logic                 grant_valid,
  output logic                 grant_we
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CLIENTS - 1);

  logic [N_CLIENTS-1:0] elig;
  logic                 found;
  logic [IDX_W-1:0]     sel_idx;
  logic [N_CLIENTS-1:0] sel_onehot;
  logic                 own_write;
  logic [IDX_W-1:0]     ptr_q;

  arb_eligibility #(.N_CLIENTS(N_CLIENTS)) u_elig (
    .req         (req),
    .req_we      (req_we),
    .conflict_in (conflict_in),
    .elig        (elig)
  );

  arb_rr_pick #(.N_CLIENTS(N_CLIENTS), .IDX_W(IDX_W)) u_pick (
    .elig       (elig),
    .ptr        (ptr_q),
    .found      (found),
    .sel_idx    (sel_idx),
    .sel_onehot (sel_onehot)
  );

  assign own_write = found & (|(sel_onehot & req_we));

  arb_conflict_link #(.CHAIN_PASS(CHAIN_PASS)) u_link (
    .own_write    (own_write),
    .conflict_in  (conflict_in),
    .conflict_out (conflict_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant       <= '0;
      grant_idx   <= '0;
      grant_valid <= 1'b0;
      grant_we    <= 1'b0;
      ptr_q       <= '0;
    end else begin
      grant       <= sel_onehot;
      grant_valid <= found;
      grant_we    <= own_write;
      if (found) begin
        grant_idx <= sel_idx;
        ptr_q     <= (sel_idx == LAST_IDX) ? '0 : sel_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/port_arbiter_chk.sv
module port_arbiter_chk #(
  parameter int N_CLIENTS  = 4,
  parameter bit CHAIN_PASS = 1'b1,
  parameter int IDX_W      = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N_CLIENTS-1:0] req,
  input logic [N_CLIENTS-1:0] req_we,
  input logic                 conflict_in,
  input logic                 conflict_out,
  input logic [N_CLIENTS-1:0] grant,
  input logic [IDX_W-1:0]     grant_idx,
  input logic                 grant_valid,
  input logic                 grant_we
);

  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_valid_R2: assert property (@(posedge clk) disable iff (rst)
    grant_valid == (|grant));

  assert_from_req_R2: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> (($past(req) & grant) == grant));

  assert_index_R3: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> grant[grant_idx]);

  assert_block_R5: assert property (@(posedge clk) disable iff (rst)
    $past(conflict_in) |-> !grant_we);

  assert_we_req_R5: assert property (@(posedge clk) disable iff (rst)
    grant_we |-> (($past(req_we) & grant) == grant) && grant_valid);

  assert_cout_prior_R6: assert property (@(posedge clk) disable iff (rst)
    grant_we |-> $past(conflict_out));

  assert_cout_follow_R6: assert property (@(posedge clk) disable iff (rst)
    (conflict_out && !conflict_in) |=> grant_we);

  generate
    if (CHAIN_PASS) begin : g_pass
      assert_pass_R7: assert property (@(posedge clk) disable iff (rst)
        conflict_in |-> conflict_out);
    end
  endgenerate

endmodule

bind port_arbiter port_arbiter_chk #(
  .N_CLIENTS  (N_CLIENTS),
  .CHAIN_PASS (CHAIN_PASS),
  .IDX_W      (IDX_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req          (req),
  .req_we       (req_we),
  .conflict_in  (conflict_in),
  .conflict_out (conflict_out),
  .grant        (grant),
  .grant_idx    (grant_idx),
  .grant_valid  (grant_valid),
  .grant_we     (grant_we)
);

// File: tb/sim_port_arbiter.sv
`timescale 1ns/1ps
module sim_port_arbiter;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [4:0] r0 = '0, w0 = '0;
  logic       c0 = 1'b0;
  logic [2:0] r1 = '0, w1 = '0;

  logic       co0, co1, gv0, gv1, gw0, gw1;
  logic [4:0] g0;
  logic [2:0] gi0;
  logic [2:0] g1;
  logic [1:0] gi1;

  port_arbiter #(.N_CLIENTS(5), .CHAIN_PASS(1'b1)) u0 (
    .clk(clk), .rst(rst), .req(r0), .req_we(w0), .conflict_in(c0),
    .conflict_out(co0), .grant(g0), .grant_idx(gi0), .grant_valid(gv0), .grant_we(gw0)
  );

  port_arbiter #(.N_CLIENTS(3), .CHAIN_PASS(1'b0)) u1 (
    .clk(clk), .rst(rst), .req(r1), .req_we(w1), .conflict_in(co0),
    .conflict_out(co1), .grant(g1), .grant_idx(gi1), .grant_valid(gv1), .grant_we(gw1)
  );

  typedef struct {
    logic [7:0] g0; int i0; logic v0; logic w0;
    logic [7:0] g1; int i1; logic v1; logic w1;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  int ptr0 = 0;
  int ptr1 = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int pick(input int ptr, input int n, input logic [7:0] elig);
    for (int i = 0; i < n; i++) begin
      int p;
      p = (ptr + i) % n;
      if (elig[p]) return p;
    end
    return -1;
  endfunction

  // Driver: applies one cycle of stimulus, checks the combinational conflict
  // outputs and pushes the expected registered result onto the scoreboard.
  task automatic step(input logic [4:0] rr0, input logic [4:0] ww0, input logic cc0,
                      input logic [2:0] rr1, input logic [2:0] ww1);
    logic [7:0] e0, e1;
    int s0, s1;
    logic own0, own1, xco0;
    exp_t it;
    @(negedge clk);
    r0 = rr0; w0 = ww0; c0 = cc0; r1 = rr1; w1 = ww1;
    #1;
    e0   = {3'b000, rr0 & ~(ww0 & {5{cc0}})};
    s0   = pick(ptr0, 5, e0);
    own0 = (s0 >= 0) && ww0[s0];
    xco0 = own0 | cc0;
    e1   = {5'b00000, rr1 & ~(ww1 & {3{xco0}})};
    s1   = pick(ptr1, 3, e1);
    own1 = (s1 >= 0) && ww1[s1];
    // R6: own write selection raises the conflict; R7: forwarding on u0 only
    chk((cc0 && !own0) ? "R7" : "R6", "u0.conflict_out", int'(co0), int'(xco0));
    chk((xco0 && !own1) ? "R7" : "R6", "u1.conflict_out", int'(co1), int'(own1));
    it.g0 = (s0 >= 0) ? (8'd1 << s0) : 8'd0;
    it.i0 = s0; it.v0 = (s0 >= 0); it.w0 = own0;
    it.g1 = (s1 >= 0) ? (8'd1 << s1) : 8'd0;
    it.i1 = s1; it.v1 = (s1 >= 0); it.w1 = own1;
    q.push_back(it);
    if (s0 >= 0) ptr0 = (s0 + 1) % 5;
    if (s1 >= 0) ptr1 = (s1 + 1) % 3;
  endtask

  // Monitor: after each rising edge, compare the registered outputs with the
  // oldest expected item.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        chk("R2", "u0.grant_valid", int'(gv0), int'(it.v0));
        chk("R4", "u0.grant", int'(g0), int'(it.g0[4:0]));
        if (it.v0) chk("R3", "u0.grant_idx", int'(gi0), it.i0);
        chk("R5", "u0.grant_we", int'(gw0), int'(it.w0));
        chk("R2", "u1.grant_valid", int'(gv1), int'(it.v1));
        chk("R4", "u1.grant", int'(g1), int'(it.g1[2:0]));
        if (it.v1) chk("R3", "u1.grant_idx", int'(gi1), it.i1);
        chk("R5", "u1.grant_we", int'(gw1), int'(it.w1));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    // requests present during reset must not produce grants (R1)
    r0 = 5'b11111; r1 = 3'b111;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "u0.grant in reset", int'(g0), 0);
    chk("R1", "u0.grant_valid in reset", int'(gv0), 0);
    chk("R1", "u1.grant_we in reset", int'(gw1), 0);
    r0 = '0; r1 = '0;
    rst = 1'b0;
    #1;
    chk("R1", "u0.grant_valid after reset", int'(gv0), 0);
    chk("R1", "u1.grant after reset", int'(g1), 0);

    // R4: full request rotation including the 4 -> 0 wrap on u0
    repeat (7) step(5'b11111, 5'b00000, 1'b0, 3'b111, 3'b000);
    // R4: sparse patterns skip idle clients
    step(5'b10010, 5'b00000, 1'b0, 3'b101, 3'b000);
    step(5'b10010, 5'b00000, 1'b0, 3'b101, 3'b000);
    step(5'b10010, 5'b00000, 1'b0, 3'b101, 3'b000);
    step(5'b00001, 5'b00000, 1'b0, 3'b010, 3'b000);
    // R2: no request gives no grant
    step(5'b00000, 5'b00000, 1'b0, 3'b000, 3'b000);
    // R5: conflict_in blocks writes only; all-write group gets nothing
    step(5'b00110, 5'b00110, 1'b1, 3'b000, 3'b000);
    step(5'b11111, 5'b01010, 1'b1, 3'b000, 3'b000);
    step(5'b11111, 5'b01010, 1'b1, 3'b000, 3'b000);
    // R6/R7: u0 write blocks u1 write while u1 read proceeds
    step(5'b01000, 5'b01000, 1'b0, 3'b011, 3'b001);
    step(5'b01000, 5'b01000, 1'b0, 3'b001, 3'b001);
    // R7: forwarded conflict reaches u1; u1 does not forward further
    step(5'b00000, 5'b00000, 1'b1, 3'b001, 3'b001);
    step(5'b00000, 5'b00000, 1'b1, 3'b010, 3'b000);
    // R6: u1 own write when upstream is quiet
    step(5'b00000, 5'b00000, 1'b0, 3'b001, 3'b001);

    lfsr = 16'hACE1;
    for (int k = 0; k < 120; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[4:0], lfsr[9:5], lfsr[15], lfsr[12:10], lfsr[14:12]);
    end
    step(5'b00000, 5'b00000, 1'b0, 3'b000, 3'b000);
    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule